// File: doc/BRIEF.md
# BCD Time-of-Day Clock Controller

This block keeps a 24-hour time of day as six packed BCD digits. Hours-tens sit in the top nibble and seconds-ones in the bottom nibble. The time advances by one second on each cycle where the one-second tick input is high. The inputs are level signals that have already been debounced: clear, hold, three mode-select keys, hour-increment and minute-increment. The block detects their edges in its own clock domain.

Two more registers hold hours and minutes: a set-time register and an alarm register. The mode decides which register the increment keys edit. It also decides whether the running time follows the set-time register, and whether the display shows the running time or the alarm setting.

In normal mode the block raises a chime enable during the first six seconds of every hour. Outside that window it raises an alarm enable while the running hours and minutes equal the alarm hours and minutes. A display decoder, a tone generator and status lamps are expected to sit around it.

Top module: `tod_clock_ctrl`

## Requirements
- R1: `disp_time` uses packed BCD. Bits [23:20] are hours-tens, [19:16] hours-ones, [15:12] minutes-tens, [11:8] minutes-ones, [7:4] seconds-tens and [3:0] seconds-ones. The running time advances by one second per tick while in mode 110 or 011, and 23:59:59 is followed by 00:00:00.
- R2: Seconds-ones 9 carries into seconds-tens. Seconds 59 wraps to 00 and carries into the minutes. Minutes 59 wraps to 00 and carries into the hours.
- R3: A high `clr_lvl` forces the running time to 00:00:00 at the next clock edge. This has priority over holding, loading and advancing.
- R4: Each high-to-low transition of `hold_lvl` toggles a hold flag. The flag is clear after reset. While the flag is set, ticks do not advance the time.
- R5: `mode_code` takes the value of `mode_keys` whenever that value is 110 (normal), 101 (set-time) or 011 (alarm-set). Any other key value leaves the mode unchanged.
- R6: A low-to-high transition of `hour_inc_lvl` adds one hour to the set-time register in mode 101, or to the alarm register in mode 011, wrapping 23 to 00. In mode 110 it changes neither register.
- R7: A low-to-high transition of `min_inc_lvl` adds one minute to the register being edited, wrapping 59 to 00. The hours of that register do not change.
- R8: In mode 101 the running time is loaded every cycle with the set-time hours and minutes and 00 seconds. In mode 011 the display shows the alarm hours and minutes with 00 seconds, while the running time keeps advancing. In the other modes the display shows the running time.
- R9: `chime_en` is high exactly when the mode is 110 and the running minutes and seconds lie in 00:00 to 00:05.
- R10: `alarm_en` is high exactly when the mode is 110, `chime_en` is low, and the running hours and minutes equal the alarm hours and minutes.
- R11: After reset the running time, set-time register and alarm register are all zero, the hold flag is clear and the mode is 110.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_1hz | input | 1 | One-second advance enable, one cycle wide |
| clr_lvl | input | 1 | Debounced clear level |
| hold_lvl | input | 1 | Debounced hold key level |
| mode_keys | input | 3 | Debounced mode-select key levels |
| hour_inc_lvl | input | 1 | Debounced hour-increment key level |
| min_inc_lvl | input | 1 | Debounced minute-increment key level |
| disp_time | output | 24 | Time selected for display, packed BCD |
| mode_code | output | 3 | Current mode, for status lamps |
| chime_en | output | 1 | Hourly chime enable |
| alarm_en | output | 1 | Alarm tone enable |

## Verification
Every input is sampled at a rising edge. Its effect on the mode, the hold flag, the edit registers and the running time appears one edge later. `disp_time`, `chime_en` and `alarm_en` are decoded from registered state with no further delay, so they are valid in the same cycle as the state they reflect. The bench drives its inputs and samples the outputs at falling edges. A behavioural model updated on each rising edge is compared at the next falling edge. The directed checks are placed on the cycle after the last stimulus edge, with tick counts chosen so that the expected time is exact.

// File: rtl/tod_pkg.sv
// Shared definitions for the time-of-day controller: field widths, mode
// codes, BCD wrap limits and the two-digit BCD successor function.
package tod_pkg;
    localparam int DIGIT_W = 4;
    localparam int FIELD_W = 2 * DIGIT_W;
    localparam int HM_W    = 2 * FIELD_W;
    localparam int TIME_W  = 3 * FIELD_W;

    typedef logic [2:0] mode_t;
    localparam mode_t MODE_RUN   = 3'b110;
    localparam mode_t MODE_SET   = 3'b101;
    localparam mode_t MODE_ALARM = 3'b011;

    localparam logic [FIELD_W-1:0] SEC_TOP  = 8'h59;
    localparam logic [FIELD_W-1:0] MIN_TOP  = 8'h59;
    localparam logic [FIELD_W-1:0] HOUR_TOP = 8'h23;

    // Next value of a two-digit BCD field that wraps to zero after 'top'.
    function automatic logic [FIELD_W-1:0] bcd_next(input logic [FIELD_W-1:0] v,
                                                    input logic [FIELD_W-1:0] top);
        if (v == top)
            return '0;
        else if (v[DIGIT_W-1:0] == 4'd9)
            return {v[FIELD_W-1:DIGIT_W] + 4'd1, 4'd0};
        else
            return {v[FIELD_W-1:DIGIT_W], v[DIGIT_W-1:0] + 4'd1};
    endfunction

    function automatic logic is_mode(input mode_t m);
        return (m == MODE_RUN) || (m == MODE_SET) || (m == MODE_ALARM);
    endfunction
endpackage

// File: rtl/tod_key_edge.sv
// Edge detector for debounced key levels.
// Gives a one-cycle pulse per bit on a rising edge, or on a falling edge
// when FALLING is 1. Assumes the inputs are already synchronous to clk.
module tod_key_edge #(
    parameter int N       = 1,
    parameter bit FALLING = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] pulse
);
    logic [N-1:0] prev_q;

    // Remember the level seen at the previous edge.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lvl;
    end

    generate
        if (FALLING) begin : g_fall
            assign pulse = prev_q & ~lvl;
        end else begin : g_rise
            assign pulse = ~prev_q & lvl;
        end
    endgenerate
endmodule

// File: rtl/tod_mode_ctrl.sv
// Mode register and hold flag.
// The mode is loaded only from a legal key pattern. The hold flag toggles on
// each hold-key release pulse.
module tod_mode_ctrl import tod_pkg::*; (
    input  logic  clk,
    input  logic  rst_n,
    input  mode_t keys,
    input  logic  hold_fall,
    output mode_t mode_q,
    output logic  hold_q
);
    // Accept only the three defined key patterns.
    always_ff @(posedge clk) begin
        if (!rst_n)             mode_q <= MODE_RUN;
        else if (is_mode(keys)) mode_q <= keys;
    end

    // Toggle hold on each release of the hold key.
    always_ff @(posedge clk) begin
        if (!rst_n)         hold_q <= 1'b0;
        else if (hold_fall) hold_q <= ~hold_q;
    end

    p_mode_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_RUN) || (mode_q == MODE_SET) || (mode_q == MODE_ALARM));
endmodule

// File: rtl/tod_edit_reg.sv
// Editable hours:minutes register, in BCD.
// Changes only while the mode equals OWNER. The minute increment wraps
// without carrying into the hours.
module tod_edit_reg import tod_pkg::*; #(
    parameter mode_t OWNER = MODE_SET
) (
    input  logic            clk,
    input  logic            rst_n,
    input  mode_t           mode,
    input  logic            hour_up,
    input  logic            min_up,
    output logic [HM_W-1:0] hm_q
);
    logic owned;
    assign owned = (mode == OWNER);

    // Hours field: step on an hour press while this register is being edited.
    always_ff @(posedge clk) begin
        if (!rst_n)                 hm_q[HM_W-1:FIELD_W] <= '0;
        else if (owned && hour_up)  hm_q[HM_W-1:FIELD_W] <= bcd_next(hm_q[HM_W-1:FIELD_W], HOUR_TOP);
    end

    // Minutes field: step on a minute press, wrapping on its own.
    always_ff @(posedge clk) begin
        if (!rst_n)                 hm_q[FIELD_W-1:0] <= '0;
        else if (owned && min_up)   hm_q[FIELD_W-1:0] <= bcd_next(hm_q[FIELD_W-1:0], MIN_TOP);
    end

    p_min_nocarry_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (owned && min_up && !hour_up) |=> (hm_q[HM_W-1:FIELD_W] == $past(hm_q[HM_W-1:FIELD_W])));

    p_hour_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (owned && hour_up && hm_q[HM_W-1:FIELD_W] == HOUR_TOP) |=> (hm_q[HM_W-1:FIELD_W] == '0));
endmodule

// File: rtl/tod_timekeeper.sv
// Running time-of-day counter in packed BCD.
// Priority order: clear, then loading from the set-time register, then
// advancing on a tick. Advancing needs the hold flag clear and the mode to be
// normal or alarm-set.
module tod_timekeeper import tod_pkg::*; (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              clr,
    input  logic              hold,
    input  mode_t             mode,
    input  logic [HM_W-1:0]   set_hm,
    output logic [TIME_W-1:0] time_q
);
    logic [FIELD_W-1:0] sec, mins, hrs;
    logic               sec_wrap, min_wrap, advance;
    logic [TIME_W-1:0]  time_nxt;

    assign sec  = time_q[FIELD_W-1:0];
    assign mins = time_q[2*FIELD_W-1:FIELD_W];
    assign hrs  = time_q[TIME_W-1:2*FIELD_W];

    // Successor time with carries between fields.
    always_comb begin
        sec_wrap = (sec == SEC_TOP);
        min_wrap = (mins == MIN_TOP);
        time_nxt = {sec_wrap && min_wrap ? bcd_next(hrs, HOUR_TOP) : hrs,
                    sec_wrap ? bcd_next(mins, MIN_TOP) : mins,
                    bcd_next(sec, SEC_TOP)};
    end

    assign advance = tick && !hold && ((mode == MODE_RUN) || (mode == MODE_ALARM));

    // Apply clear, load and advance in priority order.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)          time_q <= '0;
        else if (mode == MODE_SET)  time_q <= {set_hm, {FIELD_W{1'b0}}};
        else if (advance)           time_q <= time_nxt;
    end

    p_clear_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (time_q == '0));

    p_hold_freeze_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !clr && mode != MODE_SET) |=> $stable(time_q));

    p_bcd_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (time_q[3:0] <= 4'd9) && (time_q[7:4] <= 4'd5) && (time_q[11:8] <= 4'd9) &&
        (time_q[15:12] <= 4'd5) && (time_q[19:16] <= 4'd9) && (time_q[23:16] <= HOUR_TOP));
endmodule

// File: rtl/tod_clock_ctrl.sv
// Top level of the time-of-day controller.
// Detects key edges, keeps the mode and hold flag, holds the set-time and
// alarm registers, runs the time counter and decodes the display, chime and
// alarm enables. Assumes all key inputs are debounced and synchronous to clk.
module tod_clock_ctrl import tod_pkg::*; #(
    parameter logic [FIELD_W-1:0] CHIME_LAST_SEC = 8'h05
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick_1hz,
    input  logic        clr_lvl,
    input  logic        hold_lvl,
    input  logic [2:0]  mode_keys,
    input  logic        hour_inc_lvl,
    input  logic        min_inc_lvl,
    output logic [23:0] disp_time,
    output logic [2:0]  mode_code,
    output logic        chime_en,
    output logic        alarm_en
);
    localparam int NREG = 2;
    localparam mode_t OWNERS [NREG] = '{MODE_SET, MODE_ALARM};

    logic [1:0]        inc_rise;
    logic              hold_fall;
    mode_t             mode_q;
    logic              hold_q;
    logic [HM_W-1:0]   edit_hm [NREG];
    logic [TIME_W-1:0] time_q;

    tod_key_edge #(.N(2), .FALLING(1'b0)) u_inc_edge (
        .clk(clk), .rst_n(rst_n), .lvl({hour_inc_lvl, min_inc_lvl}), .pulse(inc_rise));

    tod_key_edge #(.N(1), .FALLING(1'b1)) u_hold_edge (
        .clk(clk), .rst_n(rst_n), .lvl(hold_lvl), .pulse(hold_fall));

    tod_mode_ctrl u_mode (
        .clk(clk), .rst_n(rst_n), .keys(mode_keys), .hold_fall(hold_fall),
        .mode_q(mode_q), .hold_q(hold_q));

    // One edit register per editing mode: index 0 set-time, index 1 alarm.
    generate
        for (genvar g = 0; g < NREG; g++) begin : g_edit
            tod_edit_reg #(.OWNER(OWNERS[g])) u_reg (
                .clk(clk), .rst_n(rst_n), .mode(mode_q),
                .hour_up(inc_rise[1]), .min_up(inc_rise[0]), .hm_q(edit_hm[g]));
        end
    endgenerate

    tod_timekeeper u_time (
        .clk(clk), .rst_n(rst_n), .tick(tick_1hz), .clr(clr_lvl), .hold(hold_q),
        .mode(mode_q), .set_hm(edit_hm[0]), .time_q(time_q));

    // Choose the displayed value and decode the two tone enables.
    always_comb begin
        disp_time = (mode_q == MODE_ALARM) ? {edit_hm[1], {FIELD_W{1'b0}}} : time_q;
        chime_en  = (mode_q == MODE_RUN) && (time_q[HM_W-1:0] <= {{FIELD_W{1'b0}}, CHIME_LAST_SEC});
        alarm_en  = (mode_q == MODE_RUN) && !chime_en && (time_q[TIME_W-1:FIELD_W] == edit_hm[1]);
    end

    assign mode_code = mode_q;

    p_tone_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_en |-> (time_q[HM_W-1:0] > {{FIELD_W{1'b0}}, CHIME_LAST_SEC}));
endmodule

// File: tb/tod_clock_ctrl_tb.sv
// Bench for tod_clock_ctrl. A behavioural model in integer seconds is updated
// on each rising edge and compared with every output at the falling edge.
// Directed checks name the requirements they cover.
module tod_clock_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_1hz = 1'b0, clr_lvl = 1'b0, hold_lvl = 1'b0;
    logic [2:0]  mode_keys = 3'b110;
    logic        hour_inc_lvl = 1'b0, min_inc_lvl = 1'b0;
    logic [23:0] disp_time;
    logic [2:0]  mode_code;
    logic        chime_en, alarm_en;

    int checks = 0, errors = 0;
    bit finished = 1'b0;

    // Model state
    int t, set_h, set_m, al_h, al_m;
    logic [2:0] md;
    bit hd, p_hold, p_hi, p_mi;

    tod_clock_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .clr_lvl(clr_lvl),
        .hold_lvl(hold_lvl), .mode_keys(mode_keys), .hour_inc_lvl(hour_inc_lvl),
        .min_inc_lvl(min_inc_lvl), .disp_time(disp_time), .mode_code(mode_code),
        .chime_en(chime_en), .alarm_en(alarm_en));

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [23:0] to_bcd(input int h, input int m, input int s);
        return {4'(h/10), 4'(h%10), 4'(m/10), 4'(m%10), 4'(s/10), 4'(s%10)};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model, advanced on each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            t = 0; set_h = 0; set_m = 0; al_h = 0; al_m = 0;
            md = 3'b110; hd = 0; p_hold = 0; p_hi = 0; p_mi = 0;
        end else begin
            logic [2:0] md_old;
            bit hd_old;
            md_old = md; hd_old = hd;
            if (clr_lvl) t = 0;
            else if (md_old == 3'b101) t = set_h*3600 + set_m*60;
            else if (tick_1hz && !hd_old && (md_old == 3'b110 || md_old == 3'b011)) t = (t + 1) % 86400;
            if (hour_inc_lvl && !p_hi) begin
                if (md_old == 3'b101) set_h = (set_h + 1) % 24;
                else if (md_old == 3'b011) al_h = (al_h + 1) % 24;
            end
            if (min_inc_lvl && !p_mi) begin
                if (md_old == 3'b101) set_m = (set_m + 1) % 60;
                else if (md_old == 3'b011) al_m = (al_m + 1) % 60;
            end
            if (p_hold && !hold_lvl) hd = !hd_old;
            if (mode_keys == 3'b110 || mode_keys == 3'b101 || mode_keys == 3'b011) md = mode_keys;
            p_hold = hold_lvl; p_hi = hour_inc_lvl; p_mi = min_inc_lvl;
        end
    end

    // Compare every output with the model on each falling edge.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            logic [23:0] e_disp;
            bit e_chime, e_alarm;
            e_disp  = (md == 3'b011) ? to_bcd(al_h, al_m, 0) : to_bcd(t/3600, (t/60)%60, t%60);
            e_chime = (md == 3'b110) && ((t % 3600) <= 5);
            e_alarm = (md == 3'b110) && !e_chime && ((t/60) == al_h*60 + al_m);
            chk("R1/R8 disp_time vs model", 32'(disp_time), 32'(e_disp));
            chk("R5 mode_code vs model", 32'(mode_code), 32'(md));
            chk("R9 chime_en vs model", 32'(chime_en), 32'(e_chime));
            chk("R10 alarm_en vs model", 32'(alarm_en), 32'(e_alarm));
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        repeat (n) begin
            tick_1hz = 1'b1; cyc(1);
            tick_1hz = 1'b0; cyc(1);
        end
    endtask

    task automatic press_hour(input int n);
        repeat (n) begin
            hour_inc_lvl = 1'b1; cyc(1);
            hour_inc_lvl = 1'b0; cyc(1);
        end
    endtask

    task automatic press_min(input int n);
        repeat (n) begin
            min_inc_lvl = 1'b1; cyc(1);
            min_inc_lvl = 1'b0; cyc(1);
        end
    endtask

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        chk("R11 reset time", 32'(disp_time), 32'h000000);
        chk("R11 reset mode", 32'(mode_code), 32'h6);
        chk("R9 chime at 00:00:00", 32'(chime_en), 32'h1);
        chk("R10 alarm masked by chime", 32'(alarm_en), 32'h0);

        ticks(5);
        chk("R9 chime at 00:00:05", 32'(chime_en), 32'h1);
        ticks(1);
        chk("R9 chime off at 00:00:06", 32'(chime_en), 32'h0);
        chk("R10 alarm on match 00:00", 32'(alarm_en), 32'h1);
        ticks(54);
        chk("R2 seconds carry into minutes", 32'(disp_time), 32'h000100);

        hold_lvl = 1'b1; ticks(3);
        chk("R4 press alone does not hold", 32'(disp_time), 32'h000103);
        hold_lvl = 1'b0; cyc(1);
        ticks(10);
        chk("R4 held after release", 32'(disp_time), 32'h000103);
        hold_lvl = 1'b1; cyc(1); hold_lvl = 1'b0; cyc(1);
        ticks(2);
        chk("R4 resumes after second release", 32'(disp_time), 32'h000105);

        clr_lvl = 1'b1; cyc(2);
        chk("R3 clear forces zero", 32'(disp_time), 32'h000000);
        clr_lvl = 1'b0;

        mode_keys = 3'b101; cyc(2);
        chk("R5 set-time mode", 32'(mode_code), 32'h5);
        chk("R8 load from set register", 32'(disp_time), 32'h000000);
        press_hour(23);
        chk("R6 hour edit to 23", 32'(disp_time), 32'h230000);
        press_hour(1);
        chk("R6 hour wraps to 00", 32'(disp_time), 32'h000000);
        press_hour(23);
        press_min(59);
        chk("R8 set value 23:59", 32'(disp_time), 32'h235900);
        press_min(1);
        chk("R7 minute wraps without hour carry", 32'(disp_time), 32'h230000);
        press_min(59);

        mode_keys = 3'b111; cyc(2);
        chk("R5 illegal pattern ignored", 32'(mode_code), 32'h5);

        mode_keys = 3'b110; cyc(1);
        ticks(60);
        chk("R1 day rollover", 32'(disp_time), 32'h000000);

        press_hour(1);
        mode_keys = 3'b011; cyc(1);
        chk("R6 hour press ignored in normal mode", 32'(disp_time), 32'h000000);
        press_min(2);
        chk("R8 alarm register shown", 32'(disp_time), 32'h000200);
        ticks(10);
        mode_keys = 3'b110; cyc(1);
        chk("R8 time advanced during alarm-set", 32'(disp_time), 32'h000010);
        ticks(120);
        chk("R10 alarm at 00:02:10", 32'(alarm_en), 32'h1);
        ticks(60);
        chk("R10 alarm off at 00:03:10", 32'(alarm_en), 32'h0);

        mode_keys = 3'b101; cyc(1);
        clr_lvl = 1'b1; cyc(1);
        chk("R3 clear beats set-time load", 32'(disp_time), 32'h000000);
        clr_lvl = 1'b0; cyc(1);
        chk("R8 load resumes after clear", 32'(disp_time), 32'h235900);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule